// File: doc/BRIEF.md
# Bridge Function Device Status Register

This block holds the 16-bit device status word of a bridge function's configuration space. The bus-interface logic reports error and abort events as single-cycle strobes. The block captures them into sticky flags. Each flag has its own qualifying rule. Some flags are gated by the parity-response or system-error enable, and one needs three conditions at once. The remaining bits are fixed: a DEVSEL timing code, a fast back-to-back capability bit, and zeros.

Software reads the word through a 16-bit configuration port and clears flags by writing ones to them. Clears apply only within the enabled byte lanes. Bit positions carry behaviour here, because the configuration software decodes them. The register sits at byte offset 06h, and the port accepts only word-aligned addresses.

Top module: `pci_stat_reg`

## Requirements
- R1: After the asynchronous reset, a read at offset 06h returns 0280h.
- R2: Bits 10:9 always read 01, bit 7 always reads 1, and bits 6:0 always read 0. Writes to these bits have no effect.
- R3: Bit 15 sets on the clock after the parity-error strobe, whatever the parity-response enable is.
- R4: Bit 14 sets after a system-error strobe only when the system-error enable is 1. Otherwise it stays unchanged.
- R5: Bit 13 sets after a master-abort strobe. Bit 12 sets after a received-target-abort strobe. Bit 11 sets after a signaled-target-abort strobe.
- R6: Bit 8 sets only when the initiator indication, the data-parity strobe and the parity-response enable are all 1 in the same cycle.
- R7: A write at offset 06h clears each flag (bits 15..11 and 8) whose write-data bit is 1. Flags whose write-data bit is 0 are left unchanged.
- R8: Byte enable bit 1 gates clears of bits 15:8, and byte enable bit 0 gates clears of bits 7:0. With the lane disabled, the written ones have no effect.
- R9: When a set event and a clearing write hit the same flag in one clock, the flag ends up set.
- R10: A read at any address other than 06h, including the unaligned 07h, returns 0. A write there changes no bit.
- R11: Read data follows the address combinationally, with no added cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_addr_i | input | 8 | Configuration byte address |
| cfg_be_i | input | 2 | Byte enables, bit 0 = low byte |
| cfg_wr_i | input | 1 | Write strobe |
| cfg_wdata_i | input | 16 | Write data |
| cfg_rdata_o | output | 16 | Read data |
| evt_perr_i | input | 1 | Parity error signal active |
| evt_serr_i | input | 1 | System error generated |
| evt_mabort_i | input | 1 | Master abort issued for downstream master or DMA cycle |
| evt_tabort_rx_i | input | 1 | Target abort received on such a cycle |
| evt_tabort_tx_i | input | 1 | Target abort signaled on a claimed cycle |
| evt_init_i | input | 1 | Bridge is the initiator of the current cycle |
| evt_dperr_i | input | 1 | Data parity error asserted (read) or observed (write) |
| perr_resp_en_i | input | 1 | Parity error response enable |
| serr_en_i | input | 1 | System error enable |

## Verification
A corrupted flag shows up at the read port on the first read after the clock edge where it went wrong. A lost set reads as 0, and a spurious set or a failed clear reads as a 1 that stays. Because the flags are sticky, a wrong state persists until software clears it. So a read after each step of a cumulative stimulus sequence exposes the fault and also tells which step caused it. Decode or lane errors appear either as nonzero data at other addresses or as flags that change after writes that should have been ignored.

// File: rtl/pci_stat_pkg.sv
`timescale 1ns/1ps
package pci_stat_pkg;
  localparam int STS_W = 16;
  localparam int BE_W  = STS_W / 8;

  localparam int B_DPED = 8;
  localparam int B_STA  = 11;
  localparam int B_RTA  = 12;
  localparam int B_RMA  = 13;
  localparam int B_SSE  = 14;
  localparam int B_DPE  = 15;

  localparam logic [STS_W-1:0] STS_FIXED = 16'h0280;
  localparam logic [STS_W-1:0] FLAG_MASK = 16'hF900;

  typedef struct packed {
    logic perr;
    logic serr;
    logic mabort;
    logic tabort_rx;
    logic tabort_tx;
    logic init_cyc;
    logic data_perr;
  } bus_evt_t;
endpackage

// File: rtl/stat_addr_dec.sv
`timescale 1ns/1ps
module stat_addr_dec
  import pci_stat_pkg::*;
#(
  parameter int               ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h06
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic              wr_i,
  output logic              hit_o,
  output logic [BE_W-1:0]   lane_we_o
);
  localparam int LSB_W = $clog2(BE_W);

  assign hit_o = (addr_i[ADDR_W-1:LSB_W] == REG_OFFSET[ADDR_W-1:LSB_W])
              && (addr_i[LSB_W-1:0] == '0);

  for (genvar l = 0; l < BE_W; l++) begin : g_lane
    assign lane_we_o[l] = wr_i & hit_o & be_i[l];
  end
endmodule

// File: rtl/stat_set_logic.sv
`timescale 1ns/1ps
module stat_set_logic
  import pci_stat_pkg::*;
(
  input  bus_evt_t          evt_i,
  input  logic              perr_resp_en_i,
  input  logic              serr_en_i,
  output logic [STS_W-1:0]  set_o
);
  always_comb begin
    set_o         = '0;
    set_o[B_DPE]  = evt_i.perr;
    set_o[B_SSE]  = evt_i.serr & serr_en_i;
    set_o[B_RMA]  = evt_i.mabort;
    set_o[B_RTA]  = evt_i.tabort_rx;
    set_o[B_STA]  = evt_i.tabort_tx;
    set_o[B_DPED] = evt_i.init_cyc & evt_i.data_perr & perr_resp_en_i;
  end
endmodule

// File: rtl/stat_flag_reg.sv
`timescale 1ns/1ps
module stat_flag_reg
  import pci_stat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STS_W-1:0]  set_i,
  input  logic [STS_W-1:0]  wdata_i,
  input  logic [BE_W-1:0]   lane_we_i,
  output logic [STS_W-1:0]  sts_o
);
  logic [STS_W-1:0] lane_mask;
  logic [STS_W-1:0] clr;
  logic [STS_W-1:0] sts_q;

  for (genvar l = 0; l < BE_W; l++) begin : g_mask
    assign lane_mask[l*8 +: 8] = {8{lane_we_i[l]}};
  end

  assign clr = wdata_i & lane_mask & FLAG_MASK;

  // set after clear: a coincident event survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= STS_FIXED;
    else         sts_q <= (((sts_q & ~clr) | set_i) & FLAG_MASK) | STS_FIXED;
  end

  assign sts_o = sts_q;
endmodule

// File: rtl/pci_stat_reg.sv
`timescale 1ns/1ps
module pci_stat_reg
  import pci_stat_pkg::*;
#(
  parameter int               ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h06
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [BE_W-1:0]   cfg_be_i,
  input  logic              cfg_wr_i,
  input  logic [STS_W-1:0]  cfg_wdata_i,
  output logic [STS_W-1:0]  cfg_rdata_o,
  input  logic              evt_perr_i,
  input  logic              evt_serr_i,
  input  logic              evt_mabort_i,
  input  logic              evt_tabort_rx_i,
  input  logic              evt_tabort_tx_i,
  input  logic              evt_init_i,
  input  logic              evt_dperr_i,
  input  logic              perr_resp_en_i,
  input  logic              serr_en_i
);
  logic             hit;
  logic [BE_W-1:0]  lane_we;
  logic [STS_W-1:0] set_vec;
  logic [STS_W-1:0] sts;
  bus_evt_t         evt;

  assign evt = '{perr: evt_perr_i, serr: evt_serr_i, mabort: evt_mabort_i,
                 tabort_rx: evt_tabort_rx_i, tabort_tx: evt_tabort_tx_i,
                 init_cyc: evt_init_i, data_perr: evt_dperr_i};

  stat_addr_dec #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_dec (
    .addr_i   (cfg_addr_i),
    .be_i     (cfg_be_i),
    .wr_i     (cfg_wr_i),
    .hit_o    (hit),
    .lane_we_o(lane_we)
  );

  stat_set_logic u_set (
    .evt_i         (evt),
    .perr_resp_en_i(perr_resp_en_i),
    .serr_en_i     (serr_en_i),
    .set_o         (set_vec)
  );

  stat_flag_reg u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_vec),
    .wdata_i  (cfg_wdata_i),
    .lane_we_i(lane_we),
    .sts_o    (sts)
  );

  assign cfg_rdata_o = hit ? sts : '0;
endmodule

// File: rtl/pci_stat_reg_chk.sv
`timescale 1ns/1ps
module pci_stat_reg_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        evt_perr_i,
  input logic        evt_serr_i,
  input logic        serr_en_i,
  input logic        evt_mabort_i,
  input logic        evt_tabort_rx_i,
  input logic        evt_init_i,
  input logic        evt_dperr_i,
  input logic        perr_resp_en_i,
  input logic        hit_i,
  input logic [1:0]  lane_we_i,
  input logic [15:0] wdata_i,
  input logic [15:0] sts_i,
  input logic [15:0] rdata_i
);
  a_r3_perr_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_perr_i |=> sts_i[15]);

  a_r4_serr_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(serr_en_i && evt_serr_i) && !sts_i[14]) |=> !sts_i[14]);

  a_r5_mabort_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_mabort_i |=> sts_i[13]);

  a_r6_dped_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(evt_init_i && evt_dperr_i && perr_resp_en_i) && !sts_i[8]) |=> !sts_i[8]);

  a_r7_rta_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_i[12] && !(lane_we_i[1] && wdata_i[12])) |=> sts_i[12]);

  a_r8_lane_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_i[13] && !lane_we_i[1]) |=> sts_i[13]);

  a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_tabort_rx_i && lane_we_i[1] && wdata_i[12]) |=> sts_i[12]);

  a_r2_low_byte_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lane_we_i[0] |=> (sts_i[7:0] == 8'h80));

  a_r2_timing_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |-> (rdata_i[10:9] == 2'b01));

  a_r10_miss_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_i |-> (rdata_i == 16'h0000));
endmodule

bind pci_stat_reg pci_stat_reg_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .evt_perr_i     (evt_perr_i),
  .evt_serr_i     (evt_serr_i),
  .serr_en_i      (serr_en_i),
  .evt_mabort_i   (evt_mabort_i),
  .evt_tabort_rx_i(evt_tabort_rx_i),
  .evt_init_i     (evt_init_i),
  .evt_dperr_i    (evt_dperr_i),
  .perr_resp_en_i (perr_resp_en_i),
  .hit_i          (hit),
  .lane_we_i      (lane_we),
  .wdata_i        (cfg_wdata_i),
  .sts_i          (sts),
  .rdata_i        (cfg_rdata_o)
);

// File: tb/pci_stat_reg_tb_top.sv
`timescale 1ns/1ps
module pci_stat_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = 8'h06;
  logic [1:0]  be = 2'b00;
  logic        wr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [6:0]  evt = '0;  // {perr,serr,mabort,tabort_rx,tabort_tx,init,dperr}
  logic        pen = 1'b0;
  logic        sen = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  pci_stat_reg dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_addr_i(addr), .cfg_be_i(be),
    .cfg_wr_i(wr), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata),
    .evt_perr_i(evt[6]), .evt_serr_i(evt[5]), .evt_mabort_i(evt[4]),
    .evt_tabort_rx_i(evt[3]), .evt_tabort_tx_i(evt[2]),
    .evt_init_i(evt[1]), .evt_dperr_i(evt[0]),
    .perr_resp_en_i(pen), .serr_en_i(sen)
  );

  // {evt[6:0], pen, sen, clear_data, expected}; each step writes clear_data with both lanes
  localparam int NV = 15;
  localparam logic [40:0] VEC [NV] = '{
    {7'b1000000, 1'b0, 1'b0, 16'h0000, 16'h8280},  // R3 perr with pen=0
    {7'b0100000, 1'b0, 1'b0, 16'h0000, 16'h8280},  // R4 serr gated off
    {7'b0100000, 1'b0, 1'b1, 16'h0000, 16'hC280},  // R4 serr enabled
    {7'b0010000, 1'b0, 1'b0, 16'h0000, 16'hE280},  // R5 master abort
    {7'b0001000, 1'b0, 1'b0, 16'h0000, 16'hF280},  // R5 target abort rx
    {7'b0000100, 1'b0, 1'b0, 16'h0000, 16'hFA80},  // R5 target abort tx
    {7'b0000011, 1'b0, 1'b0, 16'h0000, 16'hFA80},  // R6 pen off
    {7'b0000010, 1'b1, 1'b0, 16'h0000, 16'hFA80},  // R6 initiator only
    {7'b0000001, 1'b1, 1'b0, 16'h0000, 16'hFA80},  // R6 parity only
    {7'b0000011, 1'b1, 1'b0, 16'h0000, 16'hFB80},  // R6 all three
    {7'b0000000, 1'b0, 1'b0, 16'h8000, 16'h7B80},  // R7 clear bit 15
    {7'b0000000, 1'b0, 1'b0, 16'h0000, 16'h7B80},  // R7 zeros keep
    {7'b0000000, 1'b0, 1'b0, 16'hFFFF, 16'h0280},  // R7 R2 clear all, fixed stay
    {7'b1000000, 1'b0, 1'b0, 16'h8000, 16'h8280},  // R9 set beats clear
    {7'b0000000, 1'b0, 1'b0, 16'h8000, 16'h0280}   // R7 clear again
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [6:0] e, input logic p, input logic s,
                      input logic w, input logic [7:0] a, input logic [1:0] b,
                      input logic [15:0] d);
    @(negedge clk);
    evt = e; pen = p; sen = s; wr = w; addr = a; be = b; wdata = d;
    @(negedge clk);
    evt = '0; pen = 1'b0; sen = 1'b0; wr = 1'b0; be = 2'b00; wdata = '0;
    addr = 8'h06;
    #1;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check("R1 reset value", rdata, 16'h0280);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 after release", rdata, 16'h0280);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][40:34], VEC[i][33], VEC[i][32], 1'b1, 8'h06, 2'b11, VEC[i][31:16]);
      check($sformatf("vector %0d", i), rdata, VEC[i][15:0]);
    end

    // set every flag
    step(7'b1111111, 1'b1, 1'b1, 1'b0, 8'h06, 2'b00, 16'h0000);
    check("R3 R4 R5 R6 all set", rdata, 16'hFB80);
    // R8 low lane only: ones to flag bits ignored
    step(7'b0, 1'b0, 1'b0, 1'b1, 8'h06, 2'b01, 16'hFFFF);
    check("R8 low lane no clear", rdata, 16'hFB80);
    // R8 high lane clears bit 11 only
    step(7'b0, 1'b0, 1'b0, 1'b1, 8'h06, 2'b10, 16'h0800);
    check("R8 high lane clear", rdata, 16'hF380);
    // R10 other address
    step(7'b0, 1'b0, 1'b0, 1'b1, 8'h08, 2'b11, 16'hFFFF);
    check("R10 write elsewhere", rdata, 16'hF380);
    step(7'b0, 1'b0, 1'b0, 1'b1, 8'h07, 2'b11, 16'hFFFF);
    check("R10 unaligned write", rdata, 16'hF380);
    // R11 combinational read data
    addr = 8'h08; #1;
    check("R10 R11 read elsewhere", rdata, 16'h0000);
    addr = 8'h07; #1;
    check("R10 unaligned read", rdata, 16'h0000);
    addr = 8'h04; #1;
    check("R11 read offset 04h", rdata, 16'h0000);
    addr = 8'h06; #1;
    check("R11 read back", rdata, 16'hF380);
    // R2 read-only bits written with low-lane zeros and ones
    step(7'b0, 1'b0, 1'b0, 1'b1, 8'h06, 2'b11, 16'h067F);
    check("R2 fixed bits", rdata, 16'hF380);
    // R1 asynchronous reset mid-run
    #2 rst_n = 1'b0;
    #1 check("R1 async reset", rdata, 16'h0280);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 after second release", rdata, 16'h0280);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule